// File: doc/BRIEF.md
# Hybrid Array/ROM Control-Word Sequencer

This block produces the control word of a microcoded processor, one word per clock. A 16-bit instruction arrives with a valid qualifier. In the cycle it is presented, a programmable sum-of-products array produces that cycle's control word straight from the raw instruction bits. The array has 48 product terms.

For most instructions that single word is all there is: the cycle is flagged as last, and the block asks for the next instruction. When the array also reports that the instruction takes more cycles, the block hands the control bus to an internal ROM. The ROM is indexed first by a start address that the array supplies. It then steps one entry per cycle until it reaches an entry marked as the final step. Both sources feed one control bus through a multiplexer. A phase register picks the source, so no cycle has two drivers.

The array and ROM contents are fixed at elaboration through parameters.

Top module: `ucode_seq`

## Requirements
- R1: While `rst_n` is low, and after its release with no valid instruction, the block is in the first-cycle phase with `ctrl_o` = 0, `last_o` = 0 and `fetch_next_o` = 1.
- R2: Product term t fires when `(instr_i & TERM_MASK[t*16 +: 16]) == (TERM_VALUE[t*16 +: 16] & TERM_MASK[t*16 +: 16])`.
  - Each term has one OR-plane column, `OR_PLANE[t*25 +: 25]`, laid out as `{start[7:0], multi, ctrl[15:0]}`.
  - The array output is the bitwise OR of the columns of all firing terms.
  - In a first-phase cycle with `instr_valid_i` high, `ctrl_o` equals the OR'd ctrl field in that same cycle.
- R3: When no term contributes, `ctrl_o` is 0 and the instruction completes in one cycle.
- R4: If the OR'd multi bit is 0, the first cycle has `last_o` = 1 and `fetch_next_o` = 1, and the next cycle is again a first-phase cycle.
- R5: If the OR'd multi bit is 1, the first cycle has `last_o` = 0 and `fetch_next_o` = 0. The next cycle drives the ROM entry at the OR'd start address.
  - ROM entry a is `ROM_IMAGE[a*17 +: 17]`, laid out as `{last, ctrl[15:0]}`.
- R6: In the ROM phase, each cycle drives the ctrl field of the current entry and sets `last_o` = `fetch_next_o` = the entry's last bit.
  - The address advances by one per cycle.
  - After an entry whose last bit is set, the following cycle is a first-phase cycle.
- R7: The ROM address advances modulo 256, so entry 255 is followed by entry 0.
- R8: In the ROM phase, `instr_i` and `instr_valid_i` have no effect on any output.
- R9: The array drives the bus only in an instruction's first cycle. The ROM drives it only in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_i | input | 16 | Instruction word |
| instr_valid_i | input | 1 | Instruction word is present this cycle |
| ctrl_o | output | 16 | Control word for this cycle |
| last_o | output | 1 | This cycle is the final cycle of the instruction |
| fetch_next_o | output | 1 | A new instruction may be presented in the next cycle |

## Verification
The bench keeps the default geometry: 48 terms, a 16-bit control word and an 8-bit ROM address. It overrides the three programming parameters with a small program of its own.

That program has overlapping terms, so two columns OR together, including their start addresses. It has an exact-match term, a set of terms that fire but contribute nothing, and sequences of one and three ROM steps. One sequence starts at entry 255, which brings the address wrap within reach.

Changing the instruction inputs during ROM steps shows that they are ignored there.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;
  typedef enum logic {
    PH_FIRST = 1'b0,
    PH_ROM   = 1'b1
  } phase_t;
endpackage

// File: rtl/ucode_pla.sv
module ucode_pla #(
  parameter int INSTR_W = 16,
  parameter int N_TERMS = 48,
  parameter int CTRL_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int OUT_W   = CTRL_W + 1 + ADDR_W,
  parameter logic [N_TERMS*INSTR_W-1:0] TERM_MASK  = '0,
  parameter logic [N_TERMS*INSTR_W-1:0] TERM_VALUE = '0,
  parameter logic [N_TERMS*OUT_W-1:0]   OR_PLANE   = '0
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic               multi_o,
  output logic [ADDR_W-1:0]  start_o
);
  logic [N_TERMS-1:0] hit;
  logic [OUT_W-1:0]   acc;

  // AND plane: one comparator per product term
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    localparam logic [INSTR_W-1:0] M = TERM_MASK[t*INSTR_W +: INSTR_W];
    localparam logic [INSTR_W-1:0] V = TERM_VALUE[t*INSTR_W +: INSTR_W];
    assign hit[t] = ((instr_i & M) == (V & M));
  end

  // OR plane
  always_comb begin
    acc = '0;
    for (int t = 0; t < N_TERMS; t++) begin
      if (hit[t]) acc = acc | OR_PLANE[t*OUT_W +: OUT_W];
    end
  end

  assign ctrl_o  = acc[CTRL_W-1:0];
  assign multi_o = acc[CTRL_W];
  assign start_o = acc[OUT_W-1 -: ADDR_W];
endmodule

// File: rtl/ucode_rom.sv
module ucode_rom #(
  parameter int CTRL_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int ENTRY_W = CTRL_W + 1,
  parameter int DEPTH   = 1 << ADDR_W,
  parameter logic [DEPTH*ENTRY_W-1:0] ROM_IMAGE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              last_o
);
  logic [ENTRY_W-1:0] mem [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    assign mem[a] = ROM_IMAGE[a*ENTRY_W +: ENTRY_W];
  end

  logic [ENTRY_W-1:0] word;
  assign word   = mem[addr_i];
  assign ctrl_o = word[CTRL_W-1:0];
  assign last_o = word[CTRL_W];
endmodule

// File: rtl/ucode_ctl.sv
module ucode_ctl
  import ucode_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              multi_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic              rom_last_i,
  output logic              sel_rom_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              fetch_next_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  phase_t            phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic              start_multi;

  assign start_multi = (phase_q == PH_FIRST) && valid_i && multi_i;

  // next-state
  always_comb begin
    phase_d = phase_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (phase_q == PH_FIRST) begin
      if (start_multi) begin
        phase_d = PH_ROM;
        addr_d  = start_i;
        addr_en = 1'b1;
      end
    end else begin
      if (rom_last_i) begin
        phase_d = PH_FIRST;
      end else begin
        addr_d  = addr_q + ONE;
        addr_en = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_FIRST;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // outputs
  always_comb begin
    if (phase_q == PH_ROM) begin
      last_o       = rom_last_i;
      fetch_next_o = rom_last_i;
    end else begin
      last_o       = valid_i && !multi_i;
      fetch_next_o = !(valid_i && multi_i);
    end
  end

  assign sel_rom_o = (phase_q == PH_ROM);
  assign addr_o    = addr_q;

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_multi |=> (phase_q == PH_ROM) && (addr_q == $past(start_i)));

  assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_FIRST) && valid_i && !multi_i) |=> (phase_q == PH_FIRST));

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_ROM) && !rom_last_i) |=> (addr_q == $past(addr_q) + ONE));

  assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_ROM) && rom_last_i) |=> (phase_q == PH_FIRST));

  assert_rom_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_ROM) && !$past(start_multi)) |-> $past(phase_q == PH_ROM));
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq #(
  parameter int INSTR_W = 16,
  parameter int N_TERMS = 48,
  parameter int CTRL_W  = 16,
  parameter int ADDR_W  = 8,
  parameter logic [N_TERMS*INSTR_W-1:0] TERM_MASK  = '0,
  parameter logic [N_TERMS*INSTR_W-1:0] TERM_VALUE = '0,
  parameter logic [N_TERMS*(CTRL_W+1+ADDR_W)-1:0]   OR_PLANE  = '0,
  parameter logic [(1<<ADDR_W)*(CTRL_W+1)-1:0]      ROM_IMAGE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               instr_valid_i,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic               last_o,
  output logic               fetch_next_o
);
  localparam int OUT_W   = CTRL_W + 1 + ADDR_W;
  localparam int ENTRY_W = CTRL_W + 1;
  localparam int DEPTH   = 1 << ADDR_W;

  logic [CTRL_W-1:0] pla_ctrl, rom_ctrl;
  logic              pla_multi, rom_last, sel_rom;
  logic [ADDR_W-1:0] pla_start, rom_addr;

  ucode_pla #(
    .INSTR_W(INSTR_W), .N_TERMS(N_TERMS), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W),
    .OUT_W(OUT_W), .TERM_MASK(TERM_MASK), .TERM_VALUE(TERM_VALUE),
    .OR_PLANE(OR_PLANE)
  ) i_pla (
    .instr_i(instr_i), .ctrl_o(pla_ctrl), .multi_o(pla_multi), .start_o(pla_start)
  );

  ucode_rom #(
    .CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .DEPTH(DEPTH),
    .ROM_IMAGE(ROM_IMAGE)
  ) i_rom (
    .addr_i(rom_addr), .ctrl_o(rom_ctrl), .last_o(rom_last)
  );

  ucode_ctl #(.ADDR_W(ADDR_W)) i_ctl (
    .clk(clk), .rst_n(rst_n), .valid_i(instr_valid_i), .multi_i(pla_multi),
    .start_i(pla_start), .rom_last_i(rom_last), .sel_rom_o(sel_rom),
    .addr_o(rom_addr), .last_o(last_o), .fetch_next_o(fetch_next_o)
  );

  // shared control bus: one source per cycle, selected by phase
  always_comb begin
    if (sel_rom)            ctrl_o = rom_ctrl;
    else if (instr_valid_i) ctrl_o = pla_ctrl;
    else                    ctrl_o = '0;
  end

  assert_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> fetch_next_o);
endmodule

// File: tb/test_ucode_seq.sv
module test_ucode_seq;
  localparam int NT = 48;
  localparam int OW = 25;
  localparam int EW = 17;

  function automatic logic [NT*16-1:0] mk_mask();
    logic [NT*16-1:0] r;
    for (int t = 0; t < NT; t++) r[t*16 +: 16] = 16'hFFFF;
    r[0*16 +: 16] = 16'hF000;
    r[2*16 +: 16] = 16'hF000;
    r[3*16 +: 16] = 16'hFF00;
    r[5*16 +: 16] = 16'hFF00;
    return r;
  endfunction

  function automatic logic [NT*16-1:0] mk_value();
    logic [NT*16-1:0] r;
    for (int t = 0; t < NT; t++) r[t*16 +: 16] = 16'hFFFF;
    r[0*16 +: 16] = 16'h1000;
    r[1*16 +: 16] = 16'h2345;
    r[2*16 +: 16] = 16'h3000;
    r[3*16 +: 16] = 16'h3400;
    r[4*16 +: 16] = 16'h0000;
    r[5*16 +: 16] = 16'h5500;
    return r;
  endfunction

  // column layout {start[7:0], multi, ctrl[15:0]}
  function automatic logic [NT*OW-1:0] mk_or();
    logic [NT*OW-1:0] r;
    r = '0;
    r[0*OW +: OW] = {8'h00, 1'b0, 16'h0011};
    r[1*OW +: OW] = {8'h00, 1'b0, 16'h0F00};
    r[2*OW +: OW] = {8'h10, 1'b1, 16'h00A0};
    r[3*OW +: OW] = {8'h20, 1'b1, 16'h0005};
    r[4*OW +: OW] = {8'h00, 1'b0, 16'h8000};
    r[5*OW +: OW] = {8'hFF, 1'b1, 16'h0003};
    return r;
  endfunction

  // entry layout {last, ctrl[15:0]}
  function automatic logic [256*EW-1:0] mk_rom();
    logic [256*EW-1:0] r;
    r = '0;
    r[8'h10*EW +: EW] = {1'b0, 16'h0101};
    r[8'h11*EW +: EW] = {1'b0, 16'h0202};
    r[8'h12*EW +: EW] = {1'b1, 16'h0404};
    r[8'h30*EW +: EW] = {1'b1, 16'h7000};
    r[8'hFF*EW +: EW] = {1'b0, 16'h1234};
    r[8'h00*EW +: EW] = {1'b1, 16'h4321};
    return r;
  endfunction

  localparam logic [NT*16-1:0]  P_MASK  = mk_mask();
  localparam logic [NT*16-1:0]  P_VALUE = mk_value();
  localparam logic [NT*OW-1:0]  P_OR    = mk_or();
  localparam logic [256*EW-1:0] P_ROM   = mk_rom();

  logic        clk, rst_n, valid;
  logic [15:0] instr, ctrl;
  logic        last, fetch;
  int          n_chk, n_fail;
  bit          done;

  ucode_seq #(
    .TERM_MASK(P_MASK), .TERM_VALUE(P_VALUE), .OR_PLANE(P_OR), .ROM_IMAGE(P_ROM)
  ) i_ucode_seq (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .instr_valid_i(valid),
    .ctrl_o(ctrl), .last_o(last), .fetch_next_o(fetch)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] ec,
                     input logic el, input logic ef);
    n_chk++;
    if (ctrl !== ec || last !== el || fetch !== ef) begin
      n_fail++;
      $display("FAIL %s: ctrl=%h last=%b fetch=%b expected ctrl=%h last=%b fetch=%b",
               req, ctrl, last, fetch, ec, el, ef);
    end
  endtask

  // drive at negedge, sample 1 ns later (outputs are combinational)
  task automatic cyc(input logic v, input logic [15:0] i, input string req,
                     input logic [15:0] ec, input logic el, input logic ef);
    @(negedge clk);
    valid = v;
    instr = i;
    #1;
    chk(req, ec, el, ef);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; valid = 1'b0; instr = 16'h3999;
    #7;
    chk("R1 in reset", 16'h0000, 1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b0, 16'h3999, "R1 idle after reset", 16'h0000, 1'b0, 1'b1);
  endtask

  task automatic t_single();
    cyc(1'b1, 16'h1ABC, "R2 R4 masked term", 16'h0011, 1'b1, 1'b1);
    cyc(1'b1, 16'h2345, "R2 exact term", 16'h0F00, 1'b1, 1'b1);
    cyc(1'b1, 16'h0000, "R2 zero opcode", 16'h8000, 1'b1, 1'b1);
    cyc(1'b1, 16'h2344, "R3 no term", 16'h0000, 1'b1, 1'b1);
    cyc(1'b1, 16'hFFFF, "R3 empty columns", 16'h0000, 1'b1, 1'b1);
  endtask

  task automatic t_multi3();
    cyc(1'b1, 16'h3999, "R5 first cycle", 16'h00A0, 1'b0, 1'b0);
    cyc(1'b1, 16'h1ABC, "R5 R8 rom step0", 16'h0101, 1'b0, 1'b0);
    cyc(1'b0, 16'h3400, "R6 R8 rom step1", 16'h0202, 1'b0, 1'b0);
    cyc(1'b1, 16'h5500, "R6 R9 rom last", 16'h0404, 1'b1, 1'b1);
    cyc(1'b1, 16'h1ABC, "R6 R9 back to array", 16'h0011, 1'b1, 1'b1);
  endtask

  task automatic t_overlap();
    cyc(1'b1, 16'h3412, "R2 R5 overlapped terms", 16'h00A5, 1'b0, 1'b0);
    cyc(1'b1, 16'h2345, "R5 R8 OR'd start", 16'h7000, 1'b1, 1'b1);
    cyc(1'b0, 16'h1ABC, "R6 idle after seq", 16'h0000, 1'b0, 1'b1);
  endtask

  task automatic t_wrap();
    cyc(1'b1, 16'h55AA, "R5 first of wrap", 16'h0003, 1'b0, 1'b0);
    cyc(1'b1, 16'h3999, "R7 entry 255", 16'h1234, 1'b0, 1'b0);
    cyc(1'b1, 16'h3999, "R7 wrapped entry 0", 16'h4321, 1'b1, 1'b1);
    cyc(1'b1, 16'h2345, "R4 after wrap", 16'h0F00, 1'b1, 1'b1);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    t_reset();
    t_single();
    t_multi3();
    t_overlap();
    t_wrap();
    cyc(1'b0, 16'h0000, "R1 final idle", 16'h0000, 1'b0, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule